// File: doc/BRIEF.md
# Symmetric-Capable Nine-Tap FIR Filter with Paired Multipliers

This block is an eighth-order (nine-tap) FIR filter for 16-bit signed audio samples. Each time the sample strobe is high, one new sample enters a delay line and one filtered sample comes out a fixed number of clocks later. All products are formed from operands no wider than 18 bits. They are grouped into units that each form the sum of two products, and one extra single-product unit covers the odd tap. General logic then adds the unit outputs together.

A mode input picks between two ways of mapping the taps onto the units. In the general mode, each of the nine coefficients weights its own delayed sample: four paired units cover taps 0 to 7 and the single unit covers tap 8. In the symmetric mode, the filter assumes the coefficients mirror about the centre tap. Pre-adders first sum each pair of mirrored samples into a 17-bit value. Only two paired units are then loaded, with coefficients 0 to 3, and the single unit forms the centre product with coefficient 4. The 37-bit sum is rounded to the Q15 output scale and saturated to 16 bits.

Top module: `sym_fir_pair`

## Requirements
- R1: When `in_valid` is high in clock cycle N, `out_valid` is high in cycle N+3 for exactly one cycle. `out_valid` is high only in such cycles.
- R2: In general mode (`sym_mode`=0), the output is the rounded and saturated value of sum over k=0..8 of c_k·x[n-k]. Here x[n] is the sample taken with the strobe, and c_k is the signed 16-bit field `coef[16k+15:16k]`.
- R3: In symmetric mode (`sym_mode`=1), the output is the rounded and saturated value of sum over k=0..3 of c_k·(x[n-k]+x[n-8+k]), plus c_4·x[n-4]. Fields c_5 to c_8 are ignored.
- R4: Rounding adds 2^14 to the full-precision sum and then shifts it arithmetically right by 15 bits, so halves round toward plus infinity.
- R5: A rounded value above 32767 gives 32767, and one below -32768 gives -32768.
- R6: Reset clears the delay line. For the first 8 strobes after reset the output is 0, and the 9th strobe gives the first computed result.
- R7: Between results, `out_sample` holds its last value and `out_valid` stays low.
- R8: `sym_mode`, `coef` and `in_sample` are sampled only in the strobe cycle. The mode and the coefficients may change from one strobe to the next.
- R9: During and right after reset, `out_valid` is 0 and `out_sample` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Synchronous reset, active low |
| in_valid | input | 1 | Sample strobe |
| in_sample | input | 16 | Signed input sample |
| sym_mode | input | 1 | 1 selects the symmetric pre-add fold |
| coef | input | 144 | Nine signed 16-bit Q15 coefficients, c_k at bits 16k+15:16k |
| out_valid | output | 1 | Result strobe |
| out_sample | output | 16 | Rounded, saturated filtered sample |

## Verification
A wrong delay-line word or a wrong pairing of taps in a unit makes the very next result differ from a direct convolution. The error then repeats at that tap's offset as the sample moves along the line, so impulse and step inputs expose it within nine strobes. A fault in the fill counter shows as nonzero output during the first eight strobes after reset, or as zero output after them. A fault in the valid pipeline shows at once as a result arriving in the wrong cycle, or as a missing or unexpected strobe.

// File: rtl/sym_fir_pkg.sv
// Package: shared sizing constants for the paired-multiplier FIR.
// Assumes an odd tap count, so that exactly one centre tap exists.
package sym_fir_pkg;
    localparam int FIR_DATA_W = 16;   // sample width
    localparam int FIR_COEF_W = 16;   // coefficient width (Q15)
    localparam int FIR_TAPS   = 9;    // eighth order
    localparam int FIR_OPER_W = 18;   // multiplier operand ceiling
    localparam int FIR_SUM_W  = 37;   // accumulator width
    localparam int FIR_FRAC_W = 15;   // fractional bits dropped at output
endpackage

// File: rtl/fir_tap_line.sv
// Module: fir_tap_line
// Holds the last TAPS-1 samples and presents the current sample plus the
// history as one tap vector. It also counts strobes since reset, saturating
// once a full window exists.
// Assumes: the strobe is a single-cycle qualifier; reset is synchronous.
module fir_tap_line #(
    parameter int DATA_W = 16,
    parameter int TAPS   = 9
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic                     in_valid,
    input  logic signed [DATA_W-1:0] in_sample,
    output logic signed [DATA_W-1:0] hist [TAPS],
    output logic                     fill_done
);
    localparam int CNT_W = $clog2(TAPS + 1);
    localparam logic [CNT_W-1:0] FULL_CNT = CNT_W'(TAPS - 1);

    logic signed [DATA_W-1:0] dly [TAPS-1];
    logic [CNT_W-1:0]         seen_cnt;

    // Shift the delay line on each strobe; clear it on reset.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int i = 0; i < TAPS - 1; i++) begin
                dly[i] <= '0;
            end
        end else if (in_valid) begin
            dly[0] <= in_sample;
            for (int i = 1; i < TAPS - 1; i++) begin
                dly[i] <= dly[i-1];
            end
        end
    end

    // Count strobes since reset up to the full-window mark.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            seen_cnt <= '0;
        end else if (in_valid && (seen_cnt != FULL_CNT)) begin
            seen_cnt <= seen_cnt + 1'b1;
        end
    end

    assign hist[0] = in_sample;
    for (genvar k = 1; k < TAPS; k++) begin : g_hist
        assign hist[k] = dly[k-1];
    end

    // High when the sample now arriving completes a full window.
    assign fill_done = (seen_cnt == FULL_CNT);
endmodule

// File: rtl/fir_operand_sel.sv
// Module: fir_operand_sel
// First pipeline stage. It maps the tap vector and coefficients onto
// multiplier slots. Slot pairs (2u, 2u+1) feed paired unit u, and slot
// TAPS-1 feeds the single unit. In symmetric mode, mirrored samples are
// pre-added into the low slots, the middle slots are zeroed, and the centre
// tap goes to the last slot.
// Assumes: TAPS odd; OPER_W >= DATA_W+1 and OPER_W >= COEF_W.
module fir_operand_sel #(
    parameter int DATA_W = 16,
    parameter int COEF_W = 16,
    parameter int OPER_W = 18,
    parameter int TAPS   = 9
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic                     in_valid,
    input  logic                     sym_mode,
    input  logic                     fill_done,
    input  logic signed [DATA_W-1:0] hist [TAPS],
    input  logic [TAPS*COEF_W-1:0]   coef,
    output logic signed [OPER_W-1:0] slot_x [TAPS],
    output logic signed [OPER_W-1:0] slot_c [TAPS],
    output logic                     stage_valid,
    output logic                     stage_full,
    output logic                     stage_sym
);
    localparam int HALF = TAPS / 2;
    localparam int LAST = TAPS - 1;

    logic signed [COEF_W-1:0] cf [TAPS];
    logic signed [DATA_W:0]   pre [HALF];
    logic signed [OPER_W-1:0] nx [TAPS];
    logic signed [OPER_W-1:0] nc [TAPS];

    for (genvar k = 0; k < TAPS; k++) begin : g_cf
        assign cf[k] = $signed(coef[k*COEF_W +: COEF_W]);
    end

    // Pre-add each mirrored sample pair at one bit of growth.
    always_comb begin
        for (int k = 0; k < HALF; k++) begin
            pre[k] = DATA_W'(0) + hist[k] + hist[LAST-k];
        end
    end

    // Choose the slot operands for the selected mode.
    always_comb begin
        for (int k = 0; k < TAPS; k++) begin
            nx[k] = '0;
            nc[k] = '0;
        end
        if (sym_mode) begin
            for (int k = 0; k < HALF; k++) begin
                nx[k] = OPER_W'(pre[k]);
                nc[k] = OPER_W'(cf[k]);
            end
            nx[LAST] = OPER_W'(hist[HALF]);
            nc[LAST] = OPER_W'(cf[HALF]);
        end else begin
            for (int k = 0; k < TAPS; k++) begin
                nx[k] = OPER_W'(hist[k]);
                nc[k] = OPER_W'(cf[k]);
            end
        end
    end

    // Register the slot operands and stage flags when a sample arrives.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int k = 0; k < TAPS; k++) begin
                slot_x[k] <= '0;
                slot_c[k] <= '0;
            end
            stage_valid <= 1'b0;
            stage_full  <= 1'b0;
            stage_sym   <= 1'b0;
        end else begin
            stage_valid <= in_valid;
            if (in_valid) begin
                for (int k = 0; k < TAPS; k++) begin
                    slot_x[k] <= nx[k];
                    slot_c[k] <= nc[k];
                end
                stage_full <= fill_done;
                stage_sym  <= sym_mode;
            end
        end
    end
endmodule

// File: rtl/fir_prod_unit.sv
// Module: fir_prod_unit
// Multiply unit: forms NPROD signed products of OPER_W-bit operands and
// registers their sum at SUM_W bits. NPROD=2 gives the paired unit and
// NPROD=1 the single centre unit. The sum loads only when enabled.
// Assumes: SUM_W >= 2*OPER_W + NPROD - 1.
module fir_prod_unit #(
    parameter int OPER_W = 18,
    parameter int SUM_W  = 37,
    parameter int NPROD  = 2
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic                     en,
    input  logic signed [OPER_W-1:0] a [NPROD],
    input  logic signed [OPER_W-1:0] c [NPROD],
    output logic signed [SUM_W-1:0]  sum
);
    localparam int PROD_W = 2 * OPER_W;

    logic signed [PROD_W-1:0] prod [NPROD];
    logic signed [SUM_W-1:0]  total;

    // Form each product at full width.
    always_comb begin
        for (int i = 0; i < NPROD; i++) begin
            prod[i] = PROD_W'(a[i]) * PROD_W'(c[i]);
        end
    end

    // Add the products of this unit.
    always_comb begin
        total = '0;
        for (int i = 0; i < NPROD; i++) begin
            total = total + SUM_W'(prod[i]);
        end
    end

    // Register the unit sum on enable.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            sum <= '0;
        end else if (en) begin
            sum <= total;
        end
    end

    AST_UNIT_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        !en |=> $stable(sum)); // R8
endmodule

// File: rtl/fir_out_round.sv
// Module: fir_out_round
// Final stage. It adds the unit sums, rounds away FRAC_W bits with a
// half-LSB bias, saturates to DATA_W bits and registers the result. The
// result is forced to zero while the window is not yet full.
// Assumes: SUM_W has headroom for the bias add.
module fir_out_round #(
    parameter int SUM_W  = 37,
    parameter int NUM_IN = 5,
    parameter int DATA_W = 16,
    parameter int FRAC_W = 15
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic                     en,
    input  logic                     full,
    input  logic signed [SUM_W-1:0]  parts [NUM_IN],
    output logic                     out_valid,
    output logic signed [DATA_W-1:0] out_sample
);
    localparam logic signed [SUM_W-1:0] BIAS = $signed(SUM_W'(1)) <<< (FRAC_W - 1);
    localparam logic signed [SUM_W-1:0] MAXV = ($signed(SUM_W'(1)) <<< (DATA_W - 1)) - 1;
    localparam logic signed [SUM_W-1:0] MINV = -($signed(SUM_W'(1)) <<< (DATA_W - 1));

    logic signed [SUM_W-1:0]  acc;
    logic signed [SUM_W-1:0]  scaled;
    logic signed [DATA_W-1:0] clipped;

    // Add all unit outputs.
    always_comb begin
        acc = '0;
        for (int i = 0; i < NUM_IN; i++) begin
            acc = acc + parts[i];
        end
    end

    // Round half up, then clamp to the output range.
    always_comb begin
        scaled = (acc + BIAS) >>> FRAC_W;
        if (scaled > MAXV) begin
            clipped = MAXV[DATA_W-1:0];
        end else if (scaled < MINV) begin
            clipped = MINV[DATA_W-1:0];
        end else begin
            clipped = scaled[DATA_W-1:0];
        end
    end

    // Register the output sample and its strobe.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            out_valid  <= 1'b0;
            out_sample <= '0;
        end else begin
            out_valid <= en;
            if (en) begin
                out_sample <= full ? clipped : '0;
            end
        end
    end

    AST_OUT_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        !en |=> $stable(out_sample)); // R7
endmodule

// File: rtl/sym_fir_pair.sv
// Module: sym_fir_pair (top)
// Nine-tap FIR built from paired multiply units plus one single unit, with
// an optional symmetric pre-add fold. There are three register stages after
// the delay line: operands, products, rounded sum.
// Assumes: TAPS odd; coefficients in Q15; one strobe at most per clock.
module sym_fir_pair
    import sym_fir_pkg::*;
#(
    parameter int DATA_W = FIR_DATA_W,
    parameter int COEF_W = FIR_COEF_W,
    parameter int TAPS   = FIR_TAPS,
    parameter int OPER_W = FIR_OPER_W,
    parameter int SUM_W  = FIR_SUM_W,
    parameter int FRAC_W = FIR_FRAC_W
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic                     in_valid,
    input  logic signed [DATA_W-1:0] in_sample,
    input  logic                     sym_mode,
    input  logic [TAPS*COEF_W-1:0]   coef,
    output logic                     out_valid,
    output logic signed [DATA_W-1:0] out_sample
);
    localparam int HALF     = TAPS / 2;
    localparam int NUM_PAIR = (TAPS - 1) / 2;
    localparam int NUM_PART = NUM_PAIR + 1;

    logic signed [DATA_W-1:0] hist [TAPS];
    logic                     fill_done;
    logic signed [OPER_W-1:0] slot_x [TAPS];
    logic signed [OPER_W-1:0] slot_c [TAPS];
    logic                     v1, full1, sym1;
    logic                     v2, full2, sym2;
    logic signed [SUM_W-1:0]  part [NUM_PART];

    fir_tap_line #(.DATA_W(DATA_W), .TAPS(TAPS)) u_line (
        .clk       (clk),
        .rst_n     (rst_n),
        .in_valid  (in_valid),
        .in_sample (in_sample),
        .hist      (hist),
        .fill_done (fill_done)
    );

    fir_operand_sel #(
        .DATA_W(DATA_W), .COEF_W(COEF_W), .OPER_W(OPER_W), .TAPS(TAPS)
    ) u_sel (
        .clk         (clk),
        .rst_n       (rst_n),
        .in_valid    (in_valid),
        .sym_mode    (sym_mode),
        .fill_done   (fill_done),
        .hist        (hist),
        .coef        (coef),
        .slot_x      (slot_x),
        .slot_c      (slot_c),
        .stage_valid (v1),
        .stage_full  (full1),
        .stage_sym   (sym1)
    );

    for (genvar u = 0; u < NUM_PAIR; u++) begin : g_pair
        logic signed [OPER_W-1:0] ua [2];
        logic signed [OPER_W-1:0] uc [2];
        assign ua[0] = slot_x[2*u];
        assign ua[1] = slot_x[2*u+1];
        assign uc[0] = slot_c[2*u];
        assign uc[1] = slot_c[2*u+1];

        fir_prod_unit #(.OPER_W(OPER_W), .SUM_W(SUM_W), .NPROD(2)) u_pair (
            .clk   (clk),
            .rst_n (rst_n),
            .en    (v1),
            .a     (ua),
            .c     (uc),
            .sum   (part[u])
        );

        if (2 * u >= HALF) begin : g_idle_chk
            AST_SYM_UNUSED_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
                v2 && sym2 |-> part[u] == '0); // R3
        end
    end

    logic signed [OPER_W-1:0] ctr_a [1];
    logic signed [OPER_W-1:0] ctr_c [1];
    assign ctr_a[0] = slot_x[TAPS-1];
    assign ctr_c[0] = slot_c[TAPS-1];

    fir_prod_unit #(.OPER_W(OPER_W), .SUM_W(SUM_W), .NPROD(1)) u_centre (
        .clk   (clk),
        .rst_n (rst_n),
        .en    (v1),
        .a     (ctr_a),
        .c     (ctr_c),
        .sum   (part[NUM_PAIR])
    );

    // Carry the stage flags alongside the products.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            v2    <= 1'b0;
            full2 <= 1'b0;
            sym2  <= 1'b0;
        end else begin
            v2 <= v1;
            if (v1) begin
                full2 <= full1;
                sym2  <= sym1;
            end
        end
    end

    fir_out_round #(
        .SUM_W(SUM_W), .NUM_IN(NUM_PART), .DATA_W(DATA_W), .FRAC_W(FRAC_W)
    ) u_round (
        .clk        (clk),
        .rst_n      (rst_n),
        .en         (v2),
        .full       (full2),
        .parts      (part),
        .out_valid  (out_valid),
        .out_sample (out_sample)
    );

    AST_LATENCY: assert property (@(posedge clk) disable iff (!rst_n)
        in_valid |=> ##2 out_valid); // R1

    AST_EMPTY_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        in_valid && !fill_done |=> ##2 (out_sample == '0)); // R6
endmodule

// File: tb/sym_fir_pair_bench.sv
// Scoreboard bench: the driver pushes model results with their due cycle,
// and the monitor pops and compares them as results appear.
module sym_fir_pair_bench;
    localparam int CLK_PERIOD = 10;
    localparam int NT = 9;

    logic               clk = 1'b0;
    logic               rst_n = 1'b0;
    logic               in_valid = 1'b0;
    logic signed [15:0] in_sample = '0;
    logic               sym_mode = 1'b0;
    logic [NT*16-1:0]   coef = '0;
    logic               out_valid;
    logic signed [15:0] out_sample;

    sym_fir_pair u_sym_fir_pair (
        .clk        (clk),
        .rst_n      (rst_n),
        .in_valid   (in_valid),
        .in_sample  (in_sample),
        .sym_mode   (sym_mode),
        .coef       (coef),
        .out_valid  (out_valid),
        .out_sample (out_sample)
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    int     cyc = 0;
    int     checks = 0;
    int     errors = 0;
    bit     done = 0;
    int     b [NT];
    longint hist [NT];
    int     fill = 0;
    int     exp_q [$];
    int     due_q [$];
    string  tag_q [$];
    logic signed [15:0] last_out = '0;

    always @(posedge clk) cyc <= cyc + 1;

    task automatic check(bit ok, string tag, longint act, longint expv);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual %0d expected %0d", tag, act, expv);
        end
    endtask

    function automatic int model(bit sym);
        longint acc = 0;
        longint r;
        if (sym) begin
            for (int k = 0; k < 4; k++) acc += b[k] * (hist[k] + hist[8-k]);
            acc += b[4] * hist[4];
        end else begin
            for (int k = 0; k < NT; k++) acc += b[k] * hist[k];
        end
        r = (acc + 16384) >>> 15;
        if (r > 32767) r = 32767;
        if (r < -32768) r = -32768;
        return int'(r);
    endfunction

    task automatic send(int x, bit sym, string tag);
        int e;
        @(negedge clk);
        in_valid  = 1'b1;
        in_sample = x[15:0];
        sym_mode  = sym;
        for (int k = 0; k < NT; k++) coef[k*16 +: 16] = b[k][15:0];
        for (int k = NT - 1; k > 0; k--) hist[k] = hist[k-1];
        hist[0] = x;
        if (fill < NT) fill++;
        e = (fill < NT) ? 0 : model(sym);
        exp_q.push_back(e);
        due_q.push_back(cyc + 3);
        tag_q.push_back(tag);
    endtask

    task automatic idle(int n);
        for (int i = 0; i < n; i++) begin
            @(negedge clk);
            in_valid = 1'b0;
        end
    endtask

    task automatic drain();
        idle(1);
        while (exp_q.size() != 0) idle(1);
        idle(2);
    endtask

    task automatic do_reset();
        drain();
        @(negedge clk);
        rst_n = 1'b0;
        idle(3);
        rst_n = 1'b1;
        for (int k = 0; k < NT; k++) hist[k] = 0;
        fill = 0;
        @(negedge clk);
        check(out_valid == 1'b0, "R9 valid after reset", out_valid, 0);
        check(out_sample == 16'sd0, "R9 sample after reset", out_sample, 0);
    endtask

    function automatic int rnd16();
        return int'($urandom_range(0, 65535)) - 32768;
    endfunction

    // Monitor: compare results and check holding between results.
    always @(negedge clk) begin
        if (!rst_n) begin
            last_out = '0;
        end else if (!done) begin
            if (out_valid) begin
                if (exp_q.size() == 0) begin
                    check(1'b0, "R1 unexpected out_valid", 1, 0);
                end else begin
                    int e, d;
                    string t;
                    e = exp_q.pop_front();
                    d = due_q.pop_front();
                    t = tag_q.pop_front();
                    check(cyc == d, "R1 latency", cyc, d);
                    check(out_sample == 16'(e), t, out_sample, e);
                end
                last_out = out_sample;
            end else begin
                check(out_sample == last_out, "R7 hold between results", out_sample, last_out);
            end
        end
    end

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            done = 1;
            errors++;
            checks++;
            $display("FAIL watchdog expired actual 1 expected 0");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        for (int k = 0; k < NT; k++) hist[k] = 0;
        b = '{1000, -2000, 3000, 12000, 20000, 7000, -4000, 2500, -900};
        idle(4);
        rst_n = 1'b1;
        @(negedge clk);
        check(out_valid == 1'b0, "R9 valid after reset", out_valid, 0);
        check(out_sample == 16'sd0, "R9 sample after reset", out_sample, 0);

        for (int i = 0; i < 8; i++) send(rnd16() / 2, 0, "R6 fill window zero");
        for (int i = 0; i < 20; i++) send(rnd16() / 2, 0, "R2 random general");
        idle(3);

        // Impulse response in general mode, with gaps.
        for (int i = 0; i < 9; i++) send(0, 0, "R2 impulse lead");
        send(30000, 0, "R2 impulse");
        for (int i = 0; i < 9; i++) begin
            send(0, 0, "R2 impulse tail");
            if (i % 2 == 0) idle(2);
        end

        // Symmetric mode; c5..c8 hold values that must have no effect.
        b = '{1500, -2500, 4000, 9000, 18000, -32768, 32767, 12345, -777};
        for (int i = 0; i < 12; i++) send(20000, 1, "R3 step symmetric");
        for (int i = 0; i < 20; i++) begin
            send(rnd16(), 1, "R3 random symmetric");
            if (i % 3 == 0) idle(1);
        end
        for (int i = 0; i < 9; i++) send(0, 1, "R3 impulse lead");
        send(-25000, 1, "R3 impulse");
        for (int i = 0; i < 9; i++) send(0, 1, "R3 impulse tail");

        // Rounding: unit first coefficient, the rest zero.
        b = '{1, 0, 0, 0, 0, 0, 0, 0, 0};
        send(16384, 0, "R4 round half up");
        send(16383, 0, "R4 round below half");
        send(-16384, 0, "R4 round negative half");
        send(-16385, 0, "R4 round negative past half");
        send(32767, 0, "R4 round max");
        idle(2);

        // Saturation in both modes.
        b = '{32767, 32767, 32767, 32767, 32767, 32767, 32767, 32767, 32767};
        for (int i = 0; i < 9; i++) send(32767, 0, "R5 positive clip");
        for (int i = 0; i < 9; i++) send(-32768, 0, "R5 negative clip");
        for (int i = 0; i < 9; i++) send(32767, 1, "R5 positive clip symmetric");

        // Mode and coefficients changing on every strobe.
        for (int i = 0; i < 16; i++) begin
            for (int k = 0; k < NT; k++) b[k] = rnd16() / 4;
            send(rnd16(), i[0], "R8 per-strobe mode and coef");
        end

        // Reset mid-run, then refill.
        b = '{-3000, 5000, 7000, 11000, 15000, 11000, 7000, 5000, -3000};
        do_reset();
        for (int i = 0; i < 8; i++) send(24000, 1, "R6 zero after reset");
        for (int i = 0; i < 6; i++) send(24000, 1, "R6 first results after reset");
        drain();
        check(exp_q.size() == 0, "R1 every strobe produced a result", exp_q.size(), 0);

        done = 1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule